// File: doc/BRIEF.md
# HDLC-Like Transmit Framer

This block turns a stream of packets into a continuous byte-serial HDLC-style line stream. Packet bytes arrive on an 8-bit interface marked with start, end, valid and error signals, plus a packet-available indication. The framer stuffs control bytes so that the payload is transparent. It appends a 32-bit frame check sequence computed over the bytes as they arrived, before any stuffing. Between frames, and while no packet is waiting, it fills the line with flag bytes.

The downstream side pulls one byte per clock through a request input. Every byte leaving the block, flags included, can be passed through a self-synchronizing scrambler. The scrambler keeps its history across frames. A packet whose last byte carries the error marker is closed with an abort sequence instead of a check sequence. When an escape occupies an extra output slot, the packet source is held off through the enable output.

Top module: `hdlc_tx_framer`

## Requirements
- R1: `line_dat_o` changes only after a clock edge at which `line_req_i` was high; one new byte per such edge; otherwise it holds.
- R2: While `rst_ni` is low, `line_dat_o` is 0x7E and `pkt_ena_o` is low, and the scrambler history is cleared to zero.
- R3: When no frame is in progress, every requested byte is the flag 0x7E. A frame begins only after at least one flag has been sent, and only when `pkt_dav_i` is high. After the line drains, it carries nothing but flags.
- R4: A packet byte is taken at a clock edge where `pkt_ena_o` and `pkt_val_i` are both high. `pkt_ena_o` is high only during the payload phase, on a requested cycle with no escape pending. Every taken byte is sent once, in order.
- R5: A payload or check byte equal to 0x7E or 0x7D is sent as 0x7D followed by the byte XOR 0x20 in the next requested slot. No packet byte is taken in that second slot.
- R6: The check sequence is a reflected CRC-32 with polynomial 0x04C11DB7, processed bit 0 first. It is preset to all-ones at the byte marked start-of-packet and runs over the unstuffed bytes. It is sent complemented, least-significant byte first, right after the end-of-packet byte, and is followed by a flag.
- R7: If the end-of-packet byte carries `pkt_err_i`, that byte is still sent. The frame then ends with 0x7D, 0x7E in place of the check sequence.
- R8: With `scr_en_i` high, each sent bit is processed bit 0 first and equals the unscrambled bit XOR the sent bit 43 positions earlier. The history is cleared only by reset and runs on through flags and frames. With `scr_en_i` low, bytes leave unscrambled and the history holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scr_en_i | input | 1 | Scrambler enable |
| pkt_dav_i | input | 1 | A packet is available to start |
| pkt_val_i | input | 1 | Packet byte valid |
| pkt_sop_i | input | 1 | Byte is first of packet |
| pkt_eop_i | input | 1 | Byte is last of packet |
| pkt_err_i | input | 1 | Packet errored (with end-of-packet) |
| pkt_dat_i | input | 8 | Packet byte |
| pkt_ena_o | output | 1 | Framer takes a byte at this edge if valid |
| line_req_i | input | 1 | Downstream requests one byte |
| line_dat_o | output | 8 | Line byte |

## Verification
The bench uses the default parameters: a 32-bit check sequence and a 43-bit scrambler span. Because that span is shorter than six bytes, the scrambler feedback wraps within every frame and within the flag runs between frames. The bench descrambles with its own inverse and then deframes, so stuffing, aborts and check bytes are all compared after descrambling. Its packets include one-byte packets, packets dense with 0x7E and 0x7D, back-to-back packets and errored packets, under both a continuous request pattern and an irregular one.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FLAG_B = 8'h7E;
  localparam logic [BYTE_W-1:0] ESC_B  = 8'h7D;
  localparam logic [BYTE_W-1:0] ESC_X  = 8'h20;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_FCS,
    ST_ABORT
  } tx_st_e;

  function automatic logic needs_esc(logic [BYTE_W-1:0] b);
    return (b == FLAG_B) || (b == ESC_B);
  endfunction
endpackage

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc #(
  parameter int              CRC_W = 32,
  parameter int              DAT_W = 8,
  parameter logic [CRC_W-1:0] POLY = 32'hEDB88320
) (
  input  logic [CRC_W-1:0] crc_i,
  input  logic [DAT_W-1:0] dat_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] stg [DAT_W+1];

  assign stg[0] = crc_i;

  for (genvar g = 0; g < DAT_W; g++) begin : g_bit
    assign stg[g+1] = (stg[g][0] ^ dat_i[g]) ? ((stg[g] >> 1) ^ POLY) : (stg[g] >> 1);
  end

  assign crc_o = stg[DAT_W];
endmodule

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl
  import hdlc_tx_pkg::*;
#(
  parameter int               CRC_W    = 32,
  parameter logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              dav_i,
  input  logic              val_i,
  input  logic              sop_i,
  input  logic              eop_i,
  input  logic              err_i,
  input  logic [BYTE_W-1:0] dat_i,
  output logic              ena_o,
  output logic [BYTE_W-1:0] raw_o
);
  localparam int FCS_N = CRC_W / BYTE_W;
  localparam int CNT_W = (FCS_N > 1) ? $clog2(FCS_N) : 1;

  tx_st_e            st_q, st_d;
  logic              esc_q, esc_d;
  logic [BYTE_W-1:0] escb_q, escb_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CRC_W-1:0]  crc_q, crc_d, crc_base, crc_nxt, fcs_w;
  logic [BYTE_W-1:0] fcs_b, stuff_in;
  logic              stuff_en, acc;

  assign ena_o    = req_i && (st_q == ST_DATA) && !esc_q;
  assign acc      = ena_o && val_i;
  assign crc_base = sop_i ? '1 : crc_q;
  assign fcs_w    = ~crc_q;
  assign fcs_b    = fcs_w[cnt_q*BYTE_W +: BYTE_W];

  hdlc_tx_crc #(.CRC_W(CRC_W), .DAT_W(BYTE_W), .POLY(CRC_POLY)) u_crc (
    .crc_i(crc_base),
    .dat_i(dat_i),
    .crc_o(crc_nxt)
  );

  always_comb begin
    st_d     = st_q;
    esc_d    = esc_q;
    escb_d   = escb_q;
    cnt_d    = cnt_q;
    crc_d    = crc_q;
    raw_o    = FLAG_B;
    stuff_en = 1'b0;
    stuff_in = dat_i;
    if (req_i) begin
      if (esc_q) begin
        raw_o = escb_q;
        esc_d = 1'b0;
      end else begin
        unique case (st_q)
          ST_IDLE: begin
            raw_o = FLAG_B;
            if (dav_i) st_d = ST_DATA;
          end
          ST_DATA: begin
            if (acc) begin
              stuff_en = 1'b1;
              stuff_in = dat_i;
              crc_d    = crc_nxt;
              if (eop_i) begin
                st_d  = err_i ? ST_ABORT : ST_FCS;
                cnt_d = '0;
              end
            end else begin
              // underrun inside a frame: abandon it
              raw_o = ESC_B;
              st_d  = ST_IDLE;
            end
          end
          ST_FCS: begin
            stuff_en = 1'b1;
            stuff_in = fcs_b;
            cnt_d    = cnt_q + 1'b1;
            if (cnt_q == CNT_W'(FCS_N - 1)) st_d = ST_IDLE;
          end
          ST_ABORT: begin
            raw_o = ESC_B;
            st_d  = ST_IDLE;
          end
          default: st_d = ST_IDLE;
        endcase
        if (stuff_en) begin
          if (needs_esc(stuff_in)) begin
            raw_o  = ESC_B;
            esc_d  = 1'b1;
            escb_d = stuff_in ^ ESC_X;
          end else begin
            raw_o = stuff_in;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      esc_q  <= 1'b0;
      escb_q <= '0;
      cnt_q  <= '0;
      crc_q  <= '1;
    end else begin
      st_q   <= st_d;
      esc_q  <= esc_d;
      escb_q <= escb_d;
      cnt_q  <= cnt_d;
      crc_q  <= crc_d;
    end
  end

  // R5
  stall_after_esc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && needs_esc(dat_i)) |=> !ena_o);

  // R5
  no_flag_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && (st_q == ST_DATA || st_q == ST_FCS)) |-> (raw_o != FLAG_B));

  // R7
  abort_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && eop_i && err_i && !needs_esc(dat_i)) |=> (st_q == ST_ABORT));

  // R3
  idle_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && st_q == ST_IDLE && !esc_q) |-> (raw_o == FLAG_B));
endmodule

// File: rtl/hdlc_tx_scr.sv
module hdlc_tx_scr #(
  parameter int SPAN  = 43,
  parameter int DAT_W = 8,
  parameter logic [DAT_W-1:0] RST_B = 8'h7E
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             en_i,
  input  logic [DAT_W-1:0] raw_i,
  output logic [DAT_W-1:0] line_o
);
  logic [SPAN-1:0]  hist_q, hist_d;
  logic [DAT_W-1:0] scr_b;

  always_comb begin
    hist_d = hist_q;
    for (int i = 0; i < DAT_W; i++) begin
      scr_b[i] = raw_i[i] ^ hist_d[SPAN-1];
      hist_d   = {hist_d[SPAN-2:0], scr_b[i]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      line_o <= RST_B;
    end else if (req_i) begin
      line_o <= en_i ? scr_b : raw_i;
      if (en_i) hist_q <= hist_d;
    end
  end

  // R1
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(line_o));

  // R8
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !en_i) |=> (line_o == $past(raw_i)));
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
#(
  parameter int               CRC_W    = 32,
  parameter logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320,
  parameter int               SCR_SPAN = 43
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scr_en_i,
  input  logic              pkt_dav_i,
  input  logic              pkt_val_i,
  input  logic              pkt_sop_i,
  input  logic              pkt_eop_i,
  input  logic              pkt_err_i,
  input  logic [BYTE_W-1:0] pkt_dat_i,
  output logic              pkt_ena_o,
  input  logic              line_req_i,
  output logic [BYTE_W-1:0] line_dat_o
);
  logic [BYTE_W-1:0] raw_b;

  hdlc_tx_ctrl #(.CRC_W(CRC_W), .CRC_POLY(CRC_POLY)) u_ctrl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (line_req_i),
    .dav_i (pkt_dav_i),
    .val_i (pkt_val_i),
    .sop_i (pkt_sop_i),
    .eop_i (pkt_eop_i),
    .err_i (pkt_err_i),
    .dat_i (pkt_dat_i),
    .ena_o (pkt_ena_o),
    .raw_o (raw_b)
  );

  hdlc_tx_scr #(.SPAN(SCR_SPAN), .DAT_W(BYTE_W), .RST_B(FLAG_B)) u_scr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (line_req_i),
    .en_i  (scr_en_i),
    .raw_i (raw_b),
    .line_o(line_dat_o)
  );
endmodule

// File: tb/sim_hdlc_tx_framer.sv
`timescale 1ns/1ps
module sim_hdlc_tx_framer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       scr_en_i = 1'b0;
  logic       pkt_dav_i = 1'b0, pkt_val_i = 1'b0, pkt_sop_i = 1'b0;
  logic       pkt_eop_i = 1'b0, pkt_err_i = 1'b0;
  logic [7:0] pkt_dat_i = '0;
  logic       pkt_ena_o;
  logic       line_req_i = 1'b0;
  logic [7:0] line_dat_o;

  always #2.5 clk_i = ~clk_i;

  hdlc_tx_framer u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .scr_en_i(scr_en_i),
    .pkt_dav_i(pkt_dav_i), .pkt_val_i(pkt_val_i), .pkt_sop_i(pkt_sop_i),
    .pkt_eop_i(pkt_eop_i), .pkt_err_i(pkt_err_i), .pkt_dat_i(pkt_dat_i),
    .pkt_ena_o(pkt_ena_o), .line_req_i(line_req_i), .line_dat_o(line_dat_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int exp_q[$];
  int rx_buf[$];
  logic req_s = 1'b0, scr_s = 1'b0;
  logic [7:0] prev_line = 8'h7E;
  logic [63:0] rx_h = '0;
  bit esc_p = 0, in_frame = 0;
  int flags_seen = 0, consec_flags = 0, n_esc = 0;
  int req_mode = 0;
  logic [15:0] lf = 16'hACE1;
  logic [7:0] pl = 8'h5B;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(logic [7:0] x);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = x[7-i];
    return r;
  endfunction

  function automatic logic [31:0] rev32(logic [31:0] x);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = x[31-i];
    return r;
  endfunction

  // MSB-first CRC on bit-reversed bytes, result reversed back
  function automatic logic [31:0] crc_ref(int b[$]);
    logic [31:0] c = 32'hFFFFFFFF;
    foreach (b[k]) begin
      c = c ^ {rev8(b[k][7:0]), 24'h0};
      for (int j = 0; j < 8; j++) c = c[31] ? ((c << 1) ^ 32'h04C11DB7) : (c << 1);
    end
    return rev32(c);
  endfunction

  task automatic end_frame(int marker);
    int n = rx_buf.size();
    int e;
    string tag;
    for (int i = 0; i < n; i++) begin
      if (exp_q.size() == 0) begin
        chk(0, "R4", rx_buf[i], -1);
      end else begin
        e = exp_q.pop_front();
        if (marker == -1 && i >= n - 4) tag = "R6";
        else if (scr_s) tag = "R8";
        else tag = "R4";
        chk(rx_buf[i] == e, tag, rx_buf[i], e);
      end
    end
    if (exp_q.size() == 0) chk(0, "R7", marker, 0);
    else begin
      e = exp_q.pop_front();
      tag = (marker == -1) ? "R6" : "R7";
      chk(e == marker, tag, marker, e);
    end
    rx_buf.delete();
    in_frame = 0;
  endtask

  task automatic start_frame();
    chk(flags_seen >= 1, "R3", flags_seen, 1);
    flags_seen = 0;
    in_frame = 1;
  endtask

  task automatic proc(logic [7:0] b, logic scr);
    logic [7:0] d;
    if (scr) begin
      for (int i = 0; i < 8; i++) begin
        d[i] = b[i] ^ rx_h[42];
        rx_h = {rx_h[62:0], b[i]};
      end
    end else d = b;
    if (d == 8'h7E && !esc_p) consec_flags++;
    else consec_flags = 0;
    if (esc_p) begin
      esc_p = 0;
      if (d == 8'h7E) begin
        end_frame(-2);
        flags_seen = 1;
      end else begin
        chk(d == 8'h5E || d == 8'h5D, "R5", d, 8'h5E);
        rx_buf.push_back(int'(d ^ 8'h20));
        n_esc++;
      end
    end else if (d == 8'h7E) begin
      if (in_frame) end_frame(-1);
      flags_seen++;
    end else begin
      if (!in_frame) start_frame();
      if (d == 8'h7D) esc_p = 1;
      else rx_buf.push_back(int'(d));
    end
  endtask

  // monitor: a byte requested at an edge is read at the next falling edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (req_s) proc(line_dat_o, scr_s);
      else chk(line_dat_o == prev_line, "R1", line_dat_o, prev_line);
    end
    prev_line = line_dat_o;
    req_s = line_req_i && rst_ni;
    scr_s = scr_en_i;
  end

  initial begin
    @(posedge rst_ni);
    forever begin
      @(posedge clk_i); #1;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      line_req_i = (req_mode == 0) ? 1'b1 : (lf[1:0] != 2'b00);
    end
  end

  task automatic send_pkt(int b[$], bit err);
    logic [31:0] fcs;
    foreach (b[k]) exp_q.push_back(b[k]);
    if (!err) begin
      fcs = ~crc_ref(b);
      for (int k = 0; k < 4; k++) exp_q.push_back(int'(fcs[8*k +: 8]));
      exp_q.push_back(-1);
    end else exp_q.push_back(-2);
    pkt_dav_i = 1'b1;
    foreach (b[k]) begin
      pkt_dat_i = b[k][7:0];
      pkt_sop_i = (k == 0);
      pkt_eop_i = (k == b.size() - 1);
      pkt_err_i = err && (k == b.size() - 1);
      pkt_val_i = 1'b1;
      do @(negedge clk_i); while (!pkt_ena_o);
      @(posedge clk_i); #1;
    end
    pkt_val_i = 1'b0; pkt_dav_i = 1'b0;
    pkt_sop_i = 1'b0; pkt_eop_i = 1'b0; pkt_err_i = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk_i);
    #1;
  endtask

  function automatic void rnd_pkt(ref int p[$], input int len);
    p.delete();
    for (int i = 0; i < len; i++) begin
      pl = {pl[6:0], pl[7] ^ pl[5] ^ pl[4] ^ pl[3]};
      p.push_back((i % 7 == 3) ? 8'h7D : int'(pl));
    end
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    int p[$];
    int s[$];
    repeat (4) @(negedge clk_i);
    chk(line_dat_o == 8'h7E, "R2", line_dat_o, 8'h7E);
    chk(pkt_ena_o == 1'b0, "R2", pkt_ena_o, 0);
    s = {8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    chk(~crc_ref(s) == 32'hCBF43926, "R6", ~crc_ref(s), 32'hCBF43926);
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    repeat (6) @(posedge clk_i); #1;

    p = {8'h01, 8'h02, 8'h03, 8'h04, 8'h05};
    send_pkt(p, 0);
    p = {8'h7E, 8'h11, 8'h7D, 8'h5E, 8'h7E, 8'h7E, 8'h20, 8'h5D};
    send_pkt(p, 0);
    p = {8'h7E};
    send_pkt(p, 0);
    req_mode = 1;
    p = {8'hA0, 8'h7D, 8'hA2, 8'hA3};
    send_pkt(p, 1);
    rnd_pkt(p, 12);
    send_pkt(p, 0);
    drain();

    scr_en_i = 1'b1;
    repeat (20) @(posedge clk_i); #1;
    rnd_pkt(p, 20);
    send_pkt(p, 0);
    p = {8'h10, 8'h7E, 8'h12};
    send_pkt(p, 0);
    rnd_pkt(p, 6);
    send_pkt(p, 0);
    p = {8'h7D};
    send_pkt(p, 1);
    req_mode = 0;
    rnd_pkt(p, 64);
    send_pkt(p, 0);
    req_mode = 1;
    p = {8'h00};
    send_pkt(p, 0);
    drain();

    req_mode = 0;
    repeat (60) @(posedge clk_i); #1;
    chk(consec_flags >= 40, "R3", consec_flags, 40);
    chk(in_frame == 0 && esc_p == 0, "R3", in_frame, 0);
    chk(n_esc >= 8, "R5", n_esc, 8);
    chk(exp_q.size() == 0, "R4", exp_q.size(), 0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R3 actual=%0d expected=0", exp_q.size());
      summary();
      $finish;
    end
  end
endmodule